// File: doc/BRIEF.md
# Video Line Selector Gate

This block picks out one scan line, or a run of adjacent lines, from each field or frame of a video stream. It raises a gate output for the chosen lines so that a downstream switch can pass or capture their content. Timing comes from a sampled composite sync bit. Every transition of that bit, in either direction, counts as one line step. A reference edge marks the start of each field.

The reference is either the vertical pulse or the field index. When the field index is used, a polarity choice decides which of the two interlaced fields is selected. On the reference edge the block arms a start latch and loads a down-counter with the requested line number plus two. It then counts sync transitions. When the count runs out, the gate opens. The gate stays open for a programmed number of line steps. Closing the gate clears the start latch, so nothing more happens until the next reference edge.

The line-number width is a parameter. The default of 8 bits covers line numbers up to 255, and 12 bits reach beyond 2046. The run-length width is also a parameter.

Top module: `video_line_gate`

## Requirements
- R1: While reset is held, and after it is released, the gate output is low and no count is armed.
- R2: With the reference source set to vertical (0), a reference edge is a high-to-low change of the vertical input. Each reference edge loads the requested line number N plus two and arms counting.
- R3: Once counting is armed, every change of the composite sync bit (rise or fall) is one step. The gate goes high at the clock edge where step N+2 is sampled. This holds for N from 0 up to 255 at the default width.
- R4: The gate stays high for K steps, where K is the run length latched at the reference edge. It goes low at the edge where step K after opening is sampled. A run length of 0 is treated as 1.
- R5: After the gate closes, further sync changes leave the gate low until the next reference edge.
- R6: After reset, sync changes with no reference edge never raise the gate.
- R7: With the reference source set to field index (1), a reference edge is a high-to-low change of the field input XOR the polarity bit. Polarity 0 acts on the field input falling. Polarity 1 acts on it rising.
- R8: The source and polarity selects are captured only at a reference edge. They choose which signal is watched for the edges after that one. While the field index is the source, the vertical input has no effect.
- R9: A reference edge that arrives while counting or gating restarts the sequence. The gate drops at that edge and the counter reloads.
- R10: A sync change sampled at the same edge as a reference edge is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| csync_in | input | 1 | Sampled composite sync bit |
| vsync_in | input | 1 | Vertical pulse |
| field_in | input | 1 | Field index level |
| ref_sel_in | input | 1 | Reference source: 0 vertical, 1 field index |
| field_pol_in | input | 1 | Field polarity: XORed with the field index |
| line_sel_in | input | LINE_W | Requested line number N |
| run_len_in | input | RUN_W | Number of gated line steps K (0 means 1) |
| gate_out | output | 1 | High during the selected lines |

## Verification
The sync bit toggles at a fixed period, so the gated line count and the open length can be read as a step index and a cycle count.

Each stimulus pattern separates a different error:
- Line numbers 0, 1, 3 and 255 separate an off-by-one in the plus-two preload and any counter wrap at the top of the range.
- Run lengths of 0, 1, 2 and 4 expose faults in the close condition.
- Toggling with no reference edge, and toggling after the gate has closed, shows whether the start latch really blocks counting.
- A reference edge in mid-count, another in mid-gate, and one sampled together with a sync change check the restart rule and the counting priority.
- Field-index runs with each polarity, plus a vertical pulse sent while in field mode, check which edge is honoured.

// File: rtl/vlsg_pkg.sv
package vlsg_pkg;

    typedef enum logic {
        REF_VERT  = 1'b0,
        REF_FIELD = 1'b1
    } ref_src_e;

    typedef struct packed {
        ref_src_e src;
        logic     pol;
        logic     vs_prev;
        logic     fi_prev;
    } ref_state_t;

endpackage

// File: rtl/vlsg_ref_track.sv
module vlsg_ref_track
    import vlsg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic vsync_i,
    input  logic field_i,
    input  logic ref_sel_i,
    input  logic field_pol_i,
    output logic ref_fall_o
);

    ref_state_t st_d, st_q;
    logic       ref_now;
    logic       ref_old;

    always_comb begin
        st_d = st_q;
        if (st_q.src == REF_FIELD) begin
            ref_now = field_i ^ st_q.pol;
            ref_old = st_q.fi_prev ^ st_q.pol;
        end else begin
            ref_now = vsync_i;
            ref_old = st_q.vs_prev;
        end
        ref_fall_o  = ref_old & ~ref_now;
        st_d.vs_prev = vsync_i;
        st_d.fi_prev = field_i;
        if (ref_fall_o) begin
            st_d.src = ref_src_e'(ref_sel_i);
            st_d.pol = field_pol_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{src: REF_VERT, pol: 1'b0, vs_prev: 1'b0, fi_prev: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    // R8: selects only move at a reference edge
    a_r8_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_fall_o |=> ($stable(st_q.src) && $stable(st_q.pol)));

endmodule

// File: rtl/vlsg_sync_edge.sv
module vlsg_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic csync_i,
    output logic step_o
);

    logic cs_d, cs_q;

    always_comb begin
        cs_d   = csync_i;
        step_o = csync_i ^ cs_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q <= 1'b0;
        end else begin
            cs_q <= cs_d;
        end
    end

endmodule

// File: rtl/vlsg_seq.sv
module vlsg_seq #(
    parameter int LINE_W = 8,
    parameter int RUN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_fall_i,
    input  logic              step_i,
    input  logic [LINE_W-1:0] line_sel_i,
    input  logic [RUN_W-1:0]  run_len_i,
    output logic              gate_o
);

    localparam int CNT_W = LINE_W + 1;
    localparam logic [CNT_W-1:0] PRELOAD_ADD = CNT_W'(2);
    localparam logic [CNT_W-1:0] CNT_ONE     = CNT_W'(1);
    localparam logic [RUN_W-1:0] RUN_ONE     = RUN_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [RUN_W-1:0] left;
        logic             armed;
        logic             gate;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ref_fall_i) begin
            st_d.cnt   = {1'b0, line_sel_i} + PRELOAD_ADD;
            st_d.left  = (run_len_i == '0) ? RUN_ONE : run_len_i;
            st_d.armed = 1'b1;
            st_d.gate  = 1'b0;
        end else if (st_q.armed && step_i) begin
            if (!st_q.gate) begin
                st_d.cnt = st_q.cnt - CNT_ONE;
                if (st_q.cnt == CNT_ONE) begin
                    st_d.gate = 1'b1;
                end
            end else begin
                st_d.left = st_q.left - RUN_ONE;
                if (st_q.left == RUN_ONE) begin
                    st_d.gate  = 1'b0;
                    st_d.armed = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, left: '0, armed: 1'b0, gate: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign gate_o = st_q.gate;

    // R5: an open gate implies the start latch is still set
    a_r5_gate_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.gate |-> st_q.armed);

    // R3: no borrow past zero while counting
    a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && !st_q.gate) |-> (st_q.cnt != '0));

    // R3: a counted step strictly lowers the count
    a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && !st_q.gate && step_i && !ref_fall_i && st_q.cnt != CNT_ONE)
        |=> (st_q.cnt < $past(st_q.cnt)));

    // R10: with neither a step nor a reference edge the count holds
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !ref_fall_i) |=> ($stable(st_q.cnt) && $stable(st_q.gate)));

endmodule

// File: rtl/video_line_gate.sv
module video_line_gate #(
    parameter int LINE_W = 8,
    parameter int RUN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csync_in,
    input  logic              vsync_in,
    input  logic              field_in,
    input  logic              ref_sel_in,
    input  logic              field_pol_in,
    input  logic [LINE_W-1:0] line_sel_in,
    input  logic [RUN_W-1:0]  run_len_in,
    output logic              gate_out
);

    logic ref_fall;
    logic sync_step;

    vlsg_ref_track u_ref (
        .clk        (clk),
        .rst_n      (rst_n),
        .vsync_i    (vsync_in),
        .field_i    (field_in),
        .ref_sel_i  (ref_sel_in),
        .field_pol_i(field_pol_in),
        .ref_fall_o (ref_fall)
    );

    vlsg_sync_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .csync_i(csync_in),
        .step_o (sync_step)
    );

    vlsg_seq #(
        .LINE_W(LINE_W),
        .RUN_W (RUN_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_fall_i(ref_fall),
        .step_i    (sync_step),
        .line_sel_i(line_sel_in),
        .run_len_i (run_len_in),
        .gate_o    (gate_out)
    );

    // R3: the gate only opens on a counted sync step
    a_r3_open_on_step: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_out) |-> $past(sync_step && !ref_fall));

    // R9: the gate only closes on a sync step or a reference edge
    a_r9_close_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate_out) |-> $past(sync_step || ref_fall));

    // R9: a reference edge always leaves the gate low
    a_r9_ref_drops_gate: assert property (@(posedge clk) disable iff (!rst_n)
        ref_fall |=> !gate_out);

endmodule

// File: tb/video_line_gate_tb_top.sv
`timescale 1ns/1ps
module video_line_gate_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, vp = 1'b0, fi = 1'b0, rsel = 1'b0, pol = 1'b0;
    logic [7:0] line = 8'd0, run = 8'd1;
    logic       gate;

    int checks = 0, fails = 0;
    int tog_cnt = 0, first_idx = -1, hi_cnt = 0;

    // behavioural reference state
    int m_mode = 0, m_pol = 0, m_pvp = 0, m_pfi = 0, m_pcs = 0;
    int m_cnt = 0, m_left = 0, m_armed = 0, m_gate = 0;

    always #2.5 clk = ~clk;

    video_line_gate #(.LINE_W(8), .RUN_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .csync_in(cs), .vsync_in(vp), .field_in(fi),
        .ref_sel_in(rsel), .field_pol_in(pol), .line_sel_in(line),
        .run_len_in(run), .gate_out(gate)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        int rc, rp;
        bit fall, tr;
        rc = m_mode ? (int'(fi) ^ m_pol) : int'(vp);
        rp = m_mode ? (m_pfi ^ m_pol) : m_pvp;
        fall = (rp == 1) && (rc == 0);
        tr = (int'(cs) != m_pcs);
        if (fall) begin
            m_mode = rsel; m_pol = pol;
            m_cnt = int'(line) + 2;
            m_left = (run == 0) ? 1 : int'(run);
            m_armed = 1; m_gate = 0;
        end else if (m_armed == 1 && tr) begin
            if (m_gate == 0) begin
                m_cnt--;
                if (m_cnt == 0) m_gate = 1;
            end else begin
                m_left--;
                if (m_left == 0) begin m_gate = 0; m_armed = 0; end
            end
        end
        m_pvp = vp; m_pfi = fi; m_pcs = cs;
    endtask

    task automatic step(input logic ncs, input logic nvp, input logic nfi);
        @(negedge clk);
        chk("R3 R4 per-cycle gate", int'(gate), m_gate);
        if (gate) begin
            hi_cnt++;
            if (first_idx < 0) first_idx = tog_cnt;
        end
        if (ncs != cs) tog_cnt++;
        cs = ncs; vp = nvp; fi = nfi;
        @(posedge clk);
        model_edge();
    endtask

    task automatic hold(input int n);
        for (int i = 0; i < n; i++) step(cs, vp, fi);
    endtask

    task automatic toggles(input int n, input int per);
        for (int i = 0; i < n; i++) begin
            step(~cs, vp, fi);
            hold(per - 1);
        end
        hold(1);
    endtask

    task automatic vpulse();
        step(cs, 1'b1, fi);
        step(cs, 1'b1, fi);
        step(cs, 1'b0, fi);
    endtask

    task automatic clr();
        tog_cnt = 0; first_idx = -1; hi_cnt = 0;
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 gate in reset", int'(gate), 0);
        rst_n = 1'b1;
        hold(2);
        chk("R1 gate after reset", int'(gate), 0);

        // R6: no reference edge yet
        clr(); toggles(20, 3);
        chk("R6 gate count without reference", hi_cnt, 0);

        // R2 R3 R4 R5: line 3, one line
        line = 8'd3; run = 8'd1;
        vpulse(); clr(); toggles(20, 3);
        chk("R3 open step line 3", first_idx, 5);
        chk("R4 open cycles run 1", hi_cnt, 3);
        clr(); toggles(10, 3);
        chk("R5 closed after run", hi_cnt, 0);

        // R3 R4: line 0, four lines
        line = 8'd0; run = 8'd4;
        vpulse(); clr(); toggles(12, 3);
        chk("R3 open step line 0", first_idx, 2);
        chk("R4 open cycles run 4", hi_cnt, 12);

        // R4: run 0 behaves as 1
        line = 8'd1; run = 8'd0;
        vpulse(); clr(); toggles(10, 3);
        chk("R4 open step line 1", first_idx, 3);
        chk("R4 run 0 acts as 1", hi_cnt, 3);

        // R3: top of range
        line = 8'd255; run = 8'd2;
        vpulse(); clr(); toggles(262, 2);
        chk("R3 open step line 255", first_idx, 257);
        chk("R3 open cycles line 255", hi_cnt, 4);

        // R9: restart while counting
        line = 8'd10; run = 8'd1;
        vpulse(); toggles(6, 3);
        vpulse(); clr(); toggles(20, 3);
        chk("R9 restart mid count", first_idx, 12);
        chk("R9 restart open cycles", hi_cnt, 3);

        // R9: restart while gating
        line = 8'd0; run = 8'd5;
        vpulse(); toggles(3, 3);
        vpulse(); clr(); toggles(1, 3);
        chk("R9 restart mid gate drops", hi_cnt, 0);
        toggles(10, 3);

        // R10: step together with the reference edge
        line = 8'd2; run = 8'd1;
        step(cs, 1'b1, fi); step(cs, 1'b1, fi);
        step(~cs, 1'b0, fi);
        clr(); toggles(10, 3);
        chk("R10 coincident step not counted", first_idx, 4);

        // R8 R7: field index, polarity 0
        rsel = 1'b1; pol = 1'b0; line = 8'd1; run = 8'd1;
        vpulse(); toggles(10, 3);
        step(cs, vp, 1'b1); hold(2);
        clr(); vpulse(); toggles(10, 3);
        chk("R8 vertical ignored in field mode", hi_cnt, 0);
        clr(); step(cs, vp, 1'b0); toggles(10, 3);
        chk("R7 pol 0 field fall opens", first_idx, 3);

        // R7: polarity 1 captured at a field fall, then acts on rises
        pol = 1'b1;
        step(cs, vp, 1'b1); hold(2);
        step(cs, vp, 1'b0); toggles(10, 3);
        clr(); step(cs, vp, 1'b1); toggles(10, 3);
        chk("R7 pol 1 field rise opens", first_idx, 3);
        chk("R7 pol 1 open cycles", hi_cnt, 3);
        clr(); step(cs, vp, 1'b0); toggles(10, 3);
        chk("R7 pol 1 field fall ignored", hi_cnt, 0);

        summary();
    end

endmodule